// File: doc/BRIEF.md
# Three-Parallel Fast FIR Filter

This block is a block-processing FIR filter. On each clock it can accept three consecutive input samples and return three consecutive output samples. At a given clock rate it therefore moves three times as many samples as a one-sample-per-clock filter. The tap count is a multiple of three, and the taps split into three polyphase branches. The nine branch-by-lane products of a plain polyphase structure are replaced by six block-rate subfilters. Three of them act on single lanes and single branches. The other three act on sums of lanes and matching sums of branches. An input adder network sits before the subfilters, and a recombination network with one-block delays sits after them.

The coefficients are fixed at elaboration and must form a palindrome. Under that condition the middle-branch subfilter and the all-branch subfilter are themselves palindromic. Each of these two folds mirrored window positions together, so it needs only half the multipliers. History advances only on accepted blocks, so the result depends on the sequence of valid blocks and not on idle cycles between them. All arithmetic is carried at full precision, and the outputs are the exact convolution.

Top module: `fir3_fast_fir`

## Requirements
- R1: With lane 0, lane 1 and lane 2 holding samples 3k, 3k+1 and 3k+2 of the stream of accepted blocks, output lane j of block k equals the sum over n of h[n]·x[3k+j−n].
- R2: out_valid goes high after the second rising edge following the edge that accepts a block (in_valid high), and is low otherwise. Every accepted block produces exactly one output block. During and right after reset, out_valid is 0 and all three outputs read zero.
- R3: Outputs are exact, with no wrap, for full-scale inputs (all lanes at the most negative or the most positive value) with coefficients near full scale.
- R4: After reset the filter history is zero, so the first output blocks depend only on samples accepted since reset.
- R5: Cycles with in_valid low do not advance the filter history. Inserting idle cycles between blocks leaves every output value unchanged.
- R6: While out_valid is low, the three outputs hold their last values.
- R7: Asserting reset in the middle of a stream clears all history. Blocks sent after release are filtered as if the stream started there.
- R8: A unit sample in lane 0, followed by zero blocks, produces the taps h[0] to h[N−1] in order across output lanes 0, 1, 2 of successive blocks, and zeros after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block is valid this cycle |
| in_s0 | input | DW | Oldest sample of the block (signed) |
| in_s1 | input | DW | Middle sample of the block (signed) |
| in_s2 | input | DW | Newest sample of the block (signed) |
| out_valid | output | 1 | Output block is valid |
| out_y0 | output | OW | Output sample 3k (signed) |
| out_y1 | output | OW | Output sample 3k+1 (signed) |
| out_y2 | output | OW | Output sample 3k+2 (signed) |

## Verification
A table of fixed blocks is used first. It includes single-lane spikes, which show whether each lane reaches the correct branch and whether the cross-block terms land in lanes 0 and 1. Sign-alternating and ramp blocks expose errors in the subtraction paths of the recombination. A long random stream compared against a serial convolution checks the full structure. A unit impulse isolates the tap order. Full-scale blocks of either sign expose any lost width. Streams with idle gaps and a mid-stream reset show whether the one-block delays advance only on accepted blocks and whether they clear on reset.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

  localparam int NUM_SUB = 6;

  // Which polyphase branches (and matching input lanes) subfilter s combines.
  // bit p set => branch/lane p included.
  function automatic int unsigned sub_mask(input int s);
    case (s)
      0:       return 1;  // branch 0 on lane 0
      1:       return 2;  // branch 1 on lane 1
      2:       return 4;  // branch 2 on lane 2
      3:       return 3;  // (b0+b1) on (l0+l1)
      4:       return 6;  // (b1+b2) on (l1+l2)
      default: return 7;  // (b0+b1+b2) on (l0+l1+l2)
    endcase
  endfunction

  // With a palindromic full filter, branch 1 alone and the sum of all three
  // branches are palindromes; the others are not.
  function automatic bit mask_is_sym(input int unsigned mask);
    return (mask == 2) || (mask == 7);
  endfunction

endpackage

// File: rtl/fir3_subfilter.sv
module fir3_subfilter #(
  parameter int XW  = 10,
  parameter int SCW = 14,
  parameter int M   = 4,
  parameter bit SYM = 1'b0,
  parameter int AW  = 32,
  parameter logic [M*SCW-1:0] TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [XW-1:0] din,
  output logic signed [AW-1:0] dout
);

  localparam int HALF = M / 2;

  function automatic logic signed [AW-1:0] coef_w(input int i);
    logic signed [SCW-1:0] c;
    c = TAPS[i*SCW +: SCW];
    return AW'(c);
  endfunction

  logic signed [XW-1:0] win [M];
  logic signed [AW-1:0] acc;

  assign win[0] = din;

  if (M > 1) begin : g_hist
    logic signed [XW-1:0] hist [M-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < M-1; j++) hist[j] <= '0;
      end else if (en) begin
        hist[0] <= din;
        for (int j = 1; j < M-1; j++) hist[j] <= hist[j-1];
      end
    end
    for (genvar j = 1; j < M; j++) begin : g_win
      assign win[j] = hist[j-1];
    end
  end

  if (SYM) begin : g_fold
    always_comb begin
      acc = '0;
      for (int i = 0; i < HALF; i++)
        acc += coef_w(i) * (AW'(win[i]) + AW'(win[M-1-i]));
      if (M % 2 == 1)
        acc += coef_w(HALF) * AW'(win[HALF]);
    end
  end else begin : g_plain
    always_comb begin
      acc = '0;
      for (int i = 0; i < M; i++)
        acc += coef_w(i) * AW'(win[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (en) dout <= acc;
  end

endmodule

// File: rtl/fir3_fast_fir.sv
module fir3_fast_fir #(
  parameter int DW    = 8,
  parameter int CW    = 12,
  parameter int NTAPS = 12,
  parameter logic [NTAPS*CW-1:0] COEF_FLAT = {
    12'sd3, -12'sd5, 12'sd7, 12'sd12, -12'sd9, 12'sd20,
    12'sd20, -12'sd9, 12'sd12, 12'sd7, -12'sd5, 12'sd3},
  parameter int OW    = DW + CW + $clog2(NTAPS) + 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_s0,
  input  logic signed [DW-1:0] in_s1,
  input  logic signed [DW-1:0] in_s2,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y0,
  output logic signed [OW-1:0] out_y1,
  output logic signed [OW-1:0] out_y2
);

  localparam int M   = NTAPS / 3;
  localparam int XW  = DW + 2;
  localparam int SCW = CW + 2;

  // Coefficients of the subfilter formed from the branches set in mask.
  function automatic logic [M*SCW-1:0] sub_taps(input int unsigned mask);
    logic [M*SCW-1:0] r;
    int s;
    r = '0;
    for (int i = 0; i < M; i++) begin
      s = 0;
      for (int p = 0; p < 3; p++)
        if (mask[p]) s += int'(signed'(COEF_FLAT[(3*i+p)*CW +: CW]));
      r[i*SCW +: SCW] = SCW'(s);
    end
    return r;
  endfunction

  // Named events for the checker
  logic blk_accept;   // an input block enters the subfilters
  logic s_vld;        // subfilter outputs hold a fresh block
  assign blk_accept = in_valid;

  logic signed [XW-1:0] lane [3];
  assign lane[0] = XW'(in_s0);
  assign lane[1] = XW'(in_s1);
  assign lane[2] = XW'(in_s2);

  logic signed [OW-1:0] sub_p [fir3_pkg::NUM_SUB];

  for (genvar s = 0; s < fir3_pkg::NUM_SUB; s++) begin : g_sub
    localparam int unsigned MASK = fir3_pkg::sub_mask(s);
    logic signed [XW-1:0] xin;
    always_comb begin
      xin = '0;
      for (int p = 0; p < 3; p++)
        if (MASK[p]) xin += lane[p];
    end
    fir3_subfilter #(
      .XW(XW), .SCW(SCW), .M(M),
      .SYM(fir3_pkg::mask_is_sym(MASK)),
      .AW(OW), .TAPS(sub_taps(MASK))
    ) u_sf (
      .clk(clk), .rst_n(rst_n), .en(blk_accept),
      .din(xin), .dout(sub_p[s])
    );
  end

  // One-block delays of the recombination
  logic signed [OW-1:0] d_h2x2;   // delayed branch-2 product
  logic signed [OW-1:0] d_mid;    // delayed (b1+b2)(l1+l2) - b1*l1

  logic signed [OW-1:0] mid_now, pair01, lead;
  logic signed [OW-1:0] y0_n, y1_n, y2_n;

  always_comb begin
    mid_now = sub_p[4] - sub_p[1];
    pair01  = sub_p[3] - sub_p[1];
    lead    = sub_p[0] - d_h2x2;
    y0_n    = lead + d_mid;
    y1_n    = pair01 - lead;
    y2_n    = sub_p[5] - pair01 - mid_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld     <= 1'b0;
      out_valid <= 1'b0;
      d_h2x2    <= '0;
      d_mid     <= '0;
      out_y0    <= '0;
      out_y1    <= '0;
      out_y2    <= '0;
    end else begin
      s_vld     <= blk_accept;
      out_valid <= s_vld;
      if (s_vld) begin
        d_h2x2 <= sub_p[2];
        d_mid  <= mid_now;
        out_y0 <= y0_n;
        out_y1 <= y1_n;
        out_y2 <= y2_n;
      end
    end
  end

endmodule

// File: rtl/fir3_checker.sv
module fir3_checker #(
  parameter int OW = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 s_vld,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_y0,
  input logic signed [OW-1:0] out_y1,
  input logic signed [OW-1:0] out_y2,
  input logic signed [OW-1:0] d_h2x2,
  input logic signed [OW-1:0] d_mid
);

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  p_known_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));

  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_vld |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2)));

  p_hold_hist_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_vld |=> ($stable(d_h2x2) && $stable(d_mid)));

endmodule

bind fir3_fast_fir fir3_checker #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .s_vld(s_vld),
  .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2),
  .d_h2x2(d_h2x2), .d_mid(d_mid)
);

// File: tb/fir3_fast_fir_test.sv
module fir3_fast_fir_test;

  localparam int DW = 8;
  localparam int CW = 12;
  localparam int NT = 12;
  localparam int OW = DW + CW + $clog2(NT) + 6;
  localparam int H [NT] = '{1500, -2048, 2047, 900, -1700, 2047,
                            2047, -1700, 900, 2047, -2048, 1500};

  localparam int STIM [16][3] = '{
    '{0, 0, 0},      '{1, 0, 0},     '{0, 1, 0},     '{0, 0, 1},
    '{0, 0, 0},      '{5, -5, 5},    '{-7, 7, -7},   '{1, 2, 3},
    '{4, 5, 6},      '{-1, -2, -3},  '{127, 0, -128},'{-128, 127, 0},
    '{33, -64, 90},  '{0, 0, 0},     '{12, 12, 12},  '{-99, 45, -3}};

  function automatic logic [NT*CW-1:0] pack_h();
    logic [NT*CW-1:0] r;
    for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(H[k]);
    return r;
  endfunction

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [DW-1:0] in_s0 = 0, in_s1 = 0, in_s2 = 0;
  logic out_valid;
  logic signed [OW-1:0] out_y0, out_y1, out_y2;

  always #10 clk = ~clk;

  fir3_fast_fir #(.DW(DW), .CW(CW), .NTAPS(NT), .COEF_FLAT(pack_h()), .OW(OW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2));

  int nchk = 0, nfail = 0;
  bit finished = 0;
  string cur_req = "R2";

  longint xs [0:8191];
  longint expq [0:8191];
  int nx = 0, wr = 0, rd = 0;
  longint cap [0:63];
  int cap_n = 0;
  bit cap_on = 0;
  longint last_y [3] = '{0, 0, 0};
  logic sent_d1, sent_d2;

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  // Serial direct-form reference with zero initial history
  task automatic model_push(input longint v);
    longint y;
    xs[nx] = v;
    y = 0;
    for (int k = 0; k < NT; k++)
      if (nx - k >= 0) y += longint'(H[k]) * xs[nx-k];
    expq[wr] = y;
    wr++;
    nx++;
  endtask

  task automatic send(input int a, input int b, input int c);
    @(posedge clk); #2;
    in_valid = 1; in_s0 = DW'(a); in_s1 = DW'(b); in_s2 = DW'(c);
    model_push(a); model_push(b); model_push(c);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 0; in_s0 = DW'($urandom_range(0, 255));
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    in_valid = 0; rst_n = 0;
    nx = 0; wr = 0; rd = 0;
    last_y = '{0, 0, 0};
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({cur_req, " reset out_valid"}, longint'(out_valid), 0);
    chk({cur_req, " reset y0"}, longint'(out_y0), 0);
    chk({cur_req, " reset y1"}, longint'(out_y1), 0);
    chk({cur_req, " reset y2"}, longint'(out_y2), 0);
    @(posedge clk); #2;
    rst_n = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin sent_d1 <= 0; sent_d2 <= 0; end
    else begin sent_d1 <= in_valid; sent_d2 <= sent_d1; end
  end

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 valid timing", longint'(out_valid), longint'(sent_d2));
      if (out_valid) begin
        chk({cur_req, " lane0"}, longint'(out_y0), expq[rd]);
        chk({cur_req, " lane1"}, longint'(out_y1), expq[rd+1]);
        chk({cur_req, " lane2"}, longint'(out_y2), expq[rd+2]);
        rd += 3;
        if (cap_on && cap_n < 60) begin
          cap[cap_n] = out_y0; cap[cap_n+1] = out_y1; cap[cap_n+2] = out_y2;
          cap_n += 3;
        end
        last_y = '{longint'(out_y0), longint'(out_y1), longint'(out_y2)};
      end else begin
        chk("R6 hold y0", longint'(out_y0), last_y[0]);
        chk("R6 hold y1", longint'(out_y1), last_y[1]);
        chk("R6 hold y2", longint'(out_y2), last_y[2]);
      end
    end
  end

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R2";
    do_reset();

    // R4: first blocks see only their own samples (zero history)
    cur_req = "R4";
    send(100, -50, 25);
    send(-3, 8, 60);

    // R1: table of fixed blocks, then random stream
    cur_req = "R1";
    for (int i = 0; i < 16; i++) send(STIM[i][0], STIM[i][1], STIM[i][2]);
    for (int i = 0; i < 200; i++)
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128);
    idle(4);

    // R3: full-scale blocks of each sign
    cur_req = "R3";
    for (int i = 0; i < 8; i++) send(-128, -128, -128);
    for (int i = 0; i < 8; i++) send(127, 127, 127);
    for (int i = 0; i < 8; i++) send(-128, 127, -128);
    idle(4);

    // R5: idle gaps between blocks leave results unchanged
    cur_req = "R5";
    for (int i = 0; i < 30; i++) begin
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128);
      idle(i % 4);
    end
    idle(4);

    // R8: impulse reproduces the taps in order
    cur_req = "R8";
    for (int i = 0; i < 5; i++) send(0, 0, 0);
    idle(4);
    cap_n = 0; cap_on = 1;
    send(1, 0, 0);
    for (int i = 0; i < 5; i++) send(0, 0, 0);
    idle(4);
    cap_on = 0;
    for (int k = 0; k < NT; k++) chk("R8 tap order", cap[k], longint'(H[k]));
    for (int k = NT; k < 18; k++) chk("R8 tail zero", cap[k], 0);

    // R7: reset in mid-stream clears history
    cur_req = "R7";
    for (int i = 0; i < 6; i++) send(90, -90, 77);
    idle(4);
    do_reset();
    send(10, 20, 30);
    send(-40, 50, -60);
    for (int i = 0; i < 10; i++)
      send($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128);
    idle(5);

    chk("R2 all blocks output", longint'(rd), longint'(wr));
    finish_run();
  end

endmodule